// File: doc/BRIEF.md
# Synchronizable Time-Base Counter with Auxiliary PWM Output

This block is the time base of a capture/timer peripheral. It holds a wide up-counter that either runs free as a time-stamp source for capture logic, or resets on a period value to drive a single PWM pin. A compact control word selects the mode, the output polarity, the run/freeze state, a sync-in enable, a sync-out routing and a one-cycle software sync strobe.

Several instances can be chained through their sync pins. A sync event, which is an external pulse or the software strobe, can reload the counter from a phase value. The sync-out pin can forward the incoming event, flag the period match, or stay quiet. In PWM mode the period and compare values come from shadow registers. Their contents move into the active copies only when the counter meets the period, so a running period is never cut short.

Top module: `syncTimeBase`

## Requirements
- R1: After reset the control word reads 0x80 (only bit 7, the stop-wrap bit, set), the counter is 0, sync-out is 0 and the pin enable is 0. Control layout: bit0 run, bit1 mode (1 = PWM), bit2 polarity, bit3 software sync, bits5:4 sync-out select, bit6 sync-in enable, bit7 stop-wrap.
- R2: With run = 0 the counter holds its value unless a phase load occurs. With run = 1 in capture mode it adds one per clock and wraps from all ones to zero.
- R3: In capture mode (mode = 0) a counter equal to the active period does not reset it, and the active period and compare values never take the shadow values.
- R4: In PWM mode with run = 1, a counter equal to the active period becomes 0 on the next clock. On that same edge the shadow period and compare move into the active registers, using the shadow values held before that edge.
- R5: In PWM mode the pin enable is 1. The pin is (counter < active compare) when polarity = 0, and its inverse when polarity = 1.
- R6: In capture mode the pin output and the pin enable are both 0.
- R7: When the sync-in enable held before the edge is 1, a sync-in pulse or a software sync write loads the counter from the phase input on that edge, even while frozen. When the enable is 0, both are ignored.
- R8: Writing 1 to the software sync bit is a single-cycle event, and the bit always reads back 0. A write with the bit at 0 causes no load.
- R9: Sync-out is registered, one clock after its cause. Select 0 forwards (sync-in OR software sync write), select 1 flags counter equal to active period in either mode, and selects 2 and 3 hold it at 0.
- R10: If a phase load and a PWM period reset fall on the same edge, the counter takes the phase value. Sync-out with select 1 still pulses for that match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 8 | Control word write value |
| ctrlRdData | output | 8 | Control word read value |
| phaseVal | input | CNT_W | Value loaded into the counter on a sync load |
| perShWr | input | 1 | Shadow period write strobe |
| perShData | input | CNT_W | Shadow period value |
| cmpShWr | input | 1 | Shadow compare write strobe |
| cmpShData | input | CNT_W | Shadow compare value |
| syncIn | input | 1 | Incoming sync pulse |
| syncOut | output | 1 | Outgoing sync pulse |
| count | output | CNT_W | Time-base counter value |
| pwmOut | output | 1 | PWM pin output |
| pwmOe | output | 1 | PWM pin output enable |

## Verification
The hardest case to reach is a phase load landing on the exact edge where the PWM counter meets its period. The counter position is not under direct control, so the stimulus tracks it in the bench model and fires the sync pulse on the matching cycle. Both outcomes are then checked: the counter takes the phase value and the period-match sync-out pulse is still produced. A second hard case is the wrap from all ones. It is reached by phase-loading a value two below the wrap point instead of counting there.

// File: rtl/syncTimeBasePkg.sv
package syncTimeBasePkg;

  typedef struct packed {
    logic       stopWrap;
    logic       syncInEn;
    logic [1:0] syncOutSel;
    logic       swSync;
    logic       polarity;
    logic       modePwm;
    logic       run;
  } tbCtrl_t;

  localparam int CTRL_W = $bits(tbCtrl_t);
  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h80;

  typedef enum logic [1:0] {
    SO_PASS   = 2'd0,
    SO_PERIOD = 2'd1,
    SO_OFF_A  = 2'd2,
    SO_OFF_B  = 2'd3
  } syncOutSel_e;

  typedef struct packed {
    logic phaseLoad;
    logic cntReset;
    logic shadowXfer;
  } tbStrobe_t;

endpackage

// File: rtl/syncTbCtrl.sv
module syncTbCtrl
  import syncTimeBasePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              syncIn,
  input  logic              prdEq,
  output tbCtrl_t           ctrlQ,
  output tbStrobe_t         strobe,
  output logic              syncOut
);

  tbCtrl_t     wrWord;
  logic        forceEv;
  logic        syncEv;
  logic        pwmMatch;
  logic        syncOutNext;
  syncOutSel_e outSel;

  assign wrWord   = tbCtrl_t'(ctrlWrData);
  assign forceEv  = ctrlWrEn & wrWord.swSync;
  assign syncEv   = syncIn | forceEv;
  assign pwmMatch = ctrlQ.modePwm & ctrlQ.run & prdEq;
  assign outSel   = syncOutSel_e'(ctrlQ.syncOutSel);

  always_comb begin
    strobe.phaseLoad  = ctrlQ.syncInEn & syncEv;
    strobe.shadowXfer = pwmMatch;
    strobe.cntReset   = pwmMatch & ~strobe.phaseLoad;
  end

  always_comb begin
    unique case (outSel)
      SO_PASS:   syncOutNext = syncEv;
      SO_PERIOD: syncOutNext = prdEq;
      default:   syncOutNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= tbCtrl_t'(CTRL_RESET);
    end else if (ctrlWrEn) begin
      ctrlQ        <= wrWord;
      ctrlQ.swSync <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncOut <= 1'b0;
    else       syncOut <= syncOutNext;
  end

endmodule

// File: rtl/syncTbData.sv
module syncTbData
  import syncTimeBasePkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             modePwm,
  input  logic             polarity,
  input  tbStrobe_t        strobe,
  input  logic [CNT_W-1:0] phaseVal,
  input  logic             perShWr,
  input  logic [CNT_W-1:0] perShData,
  input  logic             cmpShWr,
  input  logic [CNT_W-1:0] cmpShData,
  output logic [CNT_W-1:0] count,
  output logic             prdEq,
  output logic             pwmOut,
  output logic             pwmOe
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] perShadow, cmpShadow;
  logic [CNT_W-1:0] perActive, cmpActive;
  logic             wave;

  assign prdEq = (count == perActive);
  assign wave  = (count < cmpActive);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.phaseLoad) begin
      count <= phaseVal;
    end else if (run) begin
      if (strobe.cntReset) count <= '0;
      else                 count <= count + ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perShadow <= '0;
      cmpShadow <= '0;
    end else begin
      if (perShWr) perShadow <= perShData;
      if (cmpShWr) cmpShadow <= cmpShData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perActive <= '0;
      cmpActive <= '0;
    end else if (strobe.shadowXfer) begin
      perActive <= perShadow;
      cmpActive <= cmpShadow;
    end
  end

  always_comb begin
    pwmOe  = modePwm;
    pwmOut = modePwm & (wave ^ polarity);
  end

endmodule

// File: rtl/syncTimeBase.sv
module syncTimeBase
  import syncTimeBasePkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  output logic [CTRL_W-1:0] ctrlRdData,
  input  logic [CNT_W-1:0]  phaseVal,
  input  logic              perShWr,
  input  logic [CNT_W-1:0]  perShData,
  input  logic              cmpShWr,
  input  logic [CNT_W-1:0]  cmpShData,
  input  logic              syncIn,
  output logic              syncOut,
  output logic [CNT_W-1:0]  count,
  output logic              pwmOut,
  output logic              pwmOe
);

  tbCtrl_t   ctrlQ;
  tbStrobe_t strobe;
  logic      prdEq;

  syncTbCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlWrData (ctrlWrData),
    .syncIn     (syncIn),
    .prdEq      (prdEq),
    .ctrlQ      (ctrlQ),
    .strobe     (strobe),
    .syncOut    (syncOut)
  );

  syncTbData #(.CNT_W(CNT_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .run       (ctrlQ.run),
    .modePwm   (ctrlQ.modePwm),
    .polarity  (ctrlQ.polarity),
    .strobe    (strobe),
    .phaseVal  (phaseVal),
    .perShWr   (perShWr),
    .perShData (perShData),
    .cmpShWr   (cmpShWr),
    .cmpShData (cmpShData),
    .count     (count),
    .prdEq     (prdEq),
    .pwmOut    (pwmOut),
    .pwmOe     (pwmOe)
  );

  assign ctrlRdData = ctrlQ;

endmodule

// File: rtl/syncTimeBaseChecker.sv
module syncTimeBaseChecker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctrlWrEn,
  input logic             forceWr,
  input logic             syncIn,
  input logic             run,
  input logic             modePwm,
  input logic             syncInEn,
  input logic             swReadBack,
  input logic             selHigh,
  input logic             syncOut,
  input logic [CNT_W-1:0] count,
  input logic             pwmOut,
  input logic             pwmOe
);

  logic loadReq;
  assign loadReq = syncInEn & (syncIn | (ctrlWrEn & forceWr));

  // R2: frozen counter holds
  assert_freeze_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !loadReq) |=> (count == $past(count)));

  // R2: capture counting adds one and wraps
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (run && !modePwm && !loadReq) |=> (count == CNT_W'($past(count) + 1'b1)));

  // R5: pin enabled in PWM mode
  assert_pwm_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    modePwm |-> pwmOe);

  // R6: pin idle in capture mode
  assert_pin_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !modePwm |-> (!pwmOe && !pwmOut));

  // R8: software sync bit never reads back set
  assert_sw_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrEn |=> !swReadBack);

  // R9: select 2 or 3 keeps sync-out low
  assert_sync_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    selHigh |=> !syncOut);

endmodule

bind syncTimeBase syncTimeBaseChecker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ctrlWrEn   (ctrlWrEn),
  .forceWr    (ctrlWrData[3]),
  .syncIn     (syncIn),
  .run        (ctrlRdData[0]),
  .modePwm    (ctrlRdData[1]),
  .syncInEn   (ctrlRdData[6]),
  .swReadBack (ctrlRdData[3]),
  .selHigh    (ctrlRdData[5]),
  .syncOut    (syncOut),
  .count      (count),
  .pwmOut     (pwmOut),
  .pwmOe      (pwmOe)
);

// File: tb/syncTimeBase_bench.sv
`timescale 1ns/100ps
module syncTimeBase_bench;

  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ctrlWrEn = 1'b0;
  logic [7:0]    ctrlWrData = '0;
  logic [7:0]    ctrlRdData;
  logic [CW-1:0] phaseVal = '0;
  logic          perShWr = 1'b0;
  logic [CW-1:0] perShData = '0;
  logic          cmpShWr = 1'b0;
  logic [CW-1:0] cmpShData = '0;
  logic          syncIn = 1'b0;
  logic          syncOut;
  logic [CW-1:0] count;
  logic          pwmOut;
  logic          pwmOe;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state built from the requirements
  logic [7:0]    mCtrl;
  logic [CW-1:0] mCount, mPerSh, mCmpSh, mPer, mCmp;
  logic          mSyncOut;

  always #2.5 clk = ~clk;

  syncTimeBase #(.CNT_W(CW)) u_syncTimeBase (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .ctrlRdData(ctrlRdData), .phaseVal(phaseVal), .perShWr(perShWr),
    .perShData(perShData), .cmpShWr(cmpShWr), .cmpShData(cmpShData),
    .syncIn(syncIn), .syncOut(syncOut), .count(count), .pwmOut(pwmOut),
    .pwmOe(pwmOe)
  );

  task automatic chk(string tag, string what, logic [CW-1:0] act, logic [CW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic expPin();
    if (!mCtrl[1]) return 1'b0;
    return (mCount < mCmp) ^ mCtrl[2];
  endfunction

  task automatic compareAll(string tag);
    chk(tag, "count", count, mCount);
    chk(tag, "ctrlRd", CW'(ctrlRdData), CW'(mCtrl));
    chk(tag, "syncOut", CW'(syncOut), CW'(mSyncOut));
    chk(tag, "pwmOe", CW'(pwmOe), CW'(mCtrl[1]));
    chk(tag, "pwmOut", CW'(pwmOut), CW'(expPin()));
  endtask

  // one clock: predict, advance, compare, clear strobes
  task automatic step(string tag);
    logic force_, ev, load, eq, pwmRst, soNext;
    force_ = ctrlWrEn & ctrlWrData[3];
    ev     = syncIn | force_;
    load   = mCtrl[6] & ev;
    eq     = (mCount == mPer);
    pwmRst = mCtrl[1] & mCtrl[0] & eq;
    case (mCtrl[5:4])
      2'd0:    soNext = ev;
      2'd1:    soNext = eq;
      default: soNext = 1'b0;
    endcase
    @(posedge clk);
    if (load)          mCount = phaseVal;
    else if (mCtrl[0]) mCount = pwmRst ? '0 : mCount + 1'b1;
    if (pwmRst) begin mPer = mPerSh; mCmp = mCmpSh; end
    if (perShWr) mPerSh = perShData;
    if (cmpShWr) mCmpSh = cmpShData;
    if (ctrlWrEn) mCtrl = ctrlWrData & 8'hF7;
    mSyncOut = soNext;
    @(negedge clk);
    compareAll(tag);
    ctrlWrEn = 1'b0; syncIn = 1'b0; perShWr = 1'b0; cmpShWr = 1'b0;
  endtask

  task automatic wrCtrl(logic [7:0] v, string tag);
    ctrlWrEn = 1'b1; ctrlWrData = v; step(tag);
  endtask

  task automatic pulseSync(logic [CW-1:0] ph, string tag);
    syncIn = 1'b1; phaseVal = ph; step(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired actual running expected finished");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    mCtrl = 8'h80; mCount = '0; mPerSh = '0; mCmpSh = '0;
    mPer = '0; mCmp = '0; mSyncOut = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "ctrlRd", CW'(ctrlRdData), 32'h80);
    chk("R1", "count", count, 0);
    chk("R1", "syncOut", CW'(syncOut), 0);
    chk("R1", "pwmOe", CW'(pwmOe), 0);

    // R2: freeze, then count, then wrap via phase load
    idle(3, "R2");
    chk("R2", "frozen count", count, 0);
    wrCtrl(8'h81, "R2");
    idle(4, "R2");
    chk("R2", "count after run", count, 4);
    wrCtrl(8'hC1, "R7");
    pulseSync(32'hFFFF_FFFE, "R7");
    chk("R7", "phase load", count, 32'hFFFF_FFFE);
    idle(3, "R2");
    chk("R2", "wrap", count, 1);

    // R3: capture ignores period and shadow transfer; select 1 watches active period 0
    perShWr = 1'b1; perShData = 5; step("R3");
    wrCtrl(8'hD1, "R3");
    pulseSync(0, "R3");
    idle(12, "R3");
    chk("R3", "no period reset", count, 12);

    // R4 and R5: PWM with period 9, compare 4
    perShWr = 1'b1; perShData = 9; cmpShWr = 1'b1; cmpShData = 4; step("R4");
    wrCtrl(8'hD3, "R4");
    pulseSync(0, "R4");
    idle(30, "R4");
    chk("R5", "pin enable", CW'(pwmOe), 1);
    wrCtrl(8'hD7, "R5");
    idle(20, "R5");

    // R6: back to capture
    wrCtrl(8'hD1, "R6");
    idle(5, "R6");
    chk("R6", "pin idle", CW'(pwmOut | pwmOe), 0);

    // R7: enable off, loads ignored
    wrCtrl(8'h91, "R7");
    pulseSync(32'h100, "R7");
    wrCtrl(8'h99, "R7");
    idle(2, "R7");
    chk("R7", "ignored load", CW'(count == 32'h100), 0);

    // R8: software force loads, reads 0; write of 0 no load
    wrCtrl(8'hD1, "R8");
    phaseVal = 32'h40;
    wrCtrl(8'hD9, "R8");
    chk("R8", "force load", count, 32'h40);
    chk("R8", "reads zero", CW'(ctrlRdData), 32'hD1);
    phaseVal = 32'h77;
    wrCtrl(8'hD1, "R8");
    chk("R8", "no load", count, 32'h41);

    // R9: routing of sync-out
    wrCtrl(8'h81, "R9");
    pulseSync(32'h5, "R9");
    chk("R9", "pass through", CW'(syncOut), 1);
    wrCtrl(8'hA1, "R9");
    pulseSync(32'h5, "R9");
    chk("R9", "select 2 off", CW'(syncOut), 0);
    wrCtrl(8'hB1, "R9");
    pulseSync(32'h5, "R9");
    chk("R9", "select 3 off", CW'(syncOut), 0);

    // R10: phase load on the period-match edge
    wrCtrl(8'hD3, "R10");
    pulseSync(0, "R10");
    for (int i = 0; i < 40 && mCount != 9; i++) step("R10");
    pulseSync(3, "R10");
    chk("R10", "phase wins", count, 3);
    chk("R10", "match pulse", CW'(syncOut), 1);

    // mixed random stimulus
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(99) < 5) begin
        ctrlWrEn = 1'b1;
        ctrlWrData = 8'($urandom);
        if ($urandom_range(7) != 0) ctrlWrData[0] = 1'b1;
      end
      if ($urandom_range(99) < 10) begin syncIn = 1'b1; end
      phaseVal = $urandom_range(11);
      if ($urandom_range(99) < 10) begin perShWr = 1'b1; perShData = $urandom_range(11); end
      if ($urandom_range(99) < 10) begin cmpShWr = 1'b1; cmpShData = $urandom_range(13); end
      step(mCtrl[1] ? "R4" : "R3");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule